// File: doc/BRIEF.md
# GPIO Pin Event Detector

This block watches an already-synchronized vector of GPIO pin levels and records per-pin events in sticky status bits. Each pin has four independent detector enables: a rising-edge detector, a falling-edge detector, a high-level detector and a low-level detector. Edges are judged against the level sampled on the previous clock. Any enabled detector that fires sets the pin's status bit. The bit stays set until software writes a one to it.

Pins are grouped into banks of 32. Pin `n` lives in bank `n / 32` at bit `n % 32`, and the last bank may be only partly populated. Every bank drives its own interrupt output, which is the registered OR of that bank's status bits. Software reaches the block through a simple 32-bit register port: a write strobe, a byte address and write data, with read data returned combinationally for the current address. Two further enable families, meant for asynchronous edge detection, are kept as plain read/write storage and detect nothing. Both-edge detection is obtained by setting a pin in both the rising and the falling map.

Register map (byte addresses; one word per bank, bank `b` at `base + 4*b`): status `0x40`, rising enable `0x4C`, falling enable `0x58`, high-level enable `0x64`, low-level enable `0x70`, asynchronous-rising storage `0x7C`, asynchronous-falling storage `0x88`. Bank words run at a 12-byte stride, so up to three banks (96 pins) fit the map.

Top module: `gpio_event_unit`

## Requirements
- R1: After reset every status, enable and storage word reads 0, and every bank interrupt output is 0.
- R2: The seven register families sit at the byte addresses 0x40, 0x4C, 0x58, 0x64, 0x70, 0x7C and 0x88, bank b at base+4*b. Enable and storage words read back what was written, restricted to existing pins: bits for pin numbers at or above the pin count read 0. Any address not in the map reads 0, and a write to it changes nothing.
- R3: With a pin's rising enable set, a 0 in one sample followed by a 1 in the next sets that pin's status bit at the clock edge that samples the 1.
- R4: With a pin's falling enable set, a 1 in one sample followed by a 0 in the next sets that pin's status bit.
- R5: With both the rising and falling enables of a pin set, each change of its level in either direction sets its status bit.
- R6: With a pin's high-level enable set, its status bit is set on every clock edge at which the pin samples 1.
- R7: With a pin's low-level enable set, its status bit is set on every clock edge at which the pin samples 0.
- R8: Writing the status word clears exactly the bits written as 1. Bits written as 0 keep their value, and a set bit stays set until it is cleared.
- R9: When a clear and a new event hit the same status bit in the same cycle, the event wins and the bit stays 1.
- R10: Each bank interrupt output equals the OR of that bank's status bits as they stood one clock earlier. A pin raises only the interrupt of its own bank.
- R11: The asynchronous-rising and asynchronous-falling enable words are storage only. Setting them never sets a status bit.
- R12: A level change whose matching detector is not enabled leaves the status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Byte address of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pin_level | input | NUM_PINS (54) | Synchronized pin levels |
| bank_irq | output | (NUM_PINS+31)/32 (2) | One interrupt per bank |

## Verification
The bench builds the block with 54 pins, so there is one full bank and one bank holding only 22 pins. That choice brings the unpopulated top bits of the second bank into reach. It also lets a pin in one bank be shown not to raise the other bank's interrupt, and covers a write of all ones to a partial word. Random pin levels and random register writes across both banks are run against a per-pin reference model. This brings edge, level, clear and event-versus-clear coincidences into every combination of enables.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int WORD_W      = 32;
    localparam int KIND_STRIDE = 12;
    localparam int FIRST_BASE  = 'h40;
    localparam int NUM_KINDS   = 7;

    typedef logic [WORD_W-1:0] word_t;

    // Register families in address order (the order sets the address map).
    typedef enum logic [2:0] {
        K_STAT  = 3'd0,
        K_RISE  = 3'd1,
        K_FALL  = 3'd2,
        K_HIGH  = 3'd3,
        K_LOW   = 3'd4,
        K_ARISE = 3'd5,
        K_AFALL = 3'd6,
        K_NONE  = 3'd7
    } evt_kind_e;

    // Complete state of one bank.
    typedef struct packed {
        word_t rise_en;
        word_t fall_en;
        word_t high_en;
        word_t low_en;
        word_t arise_st;
        word_t afall_st;
        word_t status;
        word_t prev;
        logic  irq;
    } bank_state_t;

    function automatic int kind_base(input int k);
        return FIRST_BASE + KIND_STRIDE * k;
    endfunction

endpackage

// File: rtl/gpio_evt_regdec.sv
module gpio_evt_regdec
    import gpio_evt_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8,
    parameter int BIDX_W    = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output evt_kind_e         kind,
    output logic [BIDX_W-1:0] bank,
    output logic              hit
);

    always_comb begin
        kind = K_NONE;
        bank = '0;
        hit  = 1'b0;
        for (int k = 0; k < NUM_KINDS; k++) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (addr == ADDR_W'(kind_base(k) + 4 * b)) begin
                    hit  = 1'b1;
                    kind = evt_kind_e'(3'(k));
                    bank = BIDX_W'(b);
                end
            end
        end
    end

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
(
    input  word_t level,
    input  word_t prev,
    input  word_t rise_en,
    input  word_t fall_en,
    input  word_t high_en,
    input  word_t low_en,
    output word_t evt
);

    word_t went_up;
    word_t went_down;

    always_comb begin
        went_up   = level & ~prev;
        went_down = ~level & prev;
        evt       = (rise_en & went_up)
                  | (fall_en & went_down)
                  | (high_en & level)
                  | (low_en  & ~level);
    end

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
    import gpio_evt_pkg::*;
#(
    parameter word_t VALID_MASK = '1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  evt_kind_e wr_kind,
    input  word_t     wdata,
    input  word_t     level,
    input  evt_kind_e rd_kind,
    output word_t     rdata,
    output word_t     status,
    output logic      irq
);

    bank_state_t st_q, st_d;
    word_t       evt;

    gpio_evt_detect u_detect (
        .level   (level & VALID_MASK),
        .prev    (st_q.prev),
        .rise_en (st_q.rise_en),
        .fall_en (st_q.fall_en),
        .high_en (st_q.high_en),
        .low_en  (st_q.low_en),
        .evt     (evt)
    );

    always_comb begin
        word_t clr_mask;
        st_d     = st_q;
        clr_mask = '0;
        st_d.prev = level & VALID_MASK;
        if (wr_en) begin
            case (wr_kind)
                K_STAT:  clr_mask      = wdata;
                K_RISE:  st_d.rise_en  = wdata & VALID_MASK;
                K_FALL:  st_d.fall_en  = wdata & VALID_MASK;
                K_HIGH:  st_d.high_en  = wdata & VALID_MASK;
                K_LOW:   st_d.low_en   = wdata & VALID_MASK;
                K_ARISE: st_d.arise_st = wdata & VALID_MASK;
                K_AFALL: st_d.afall_st = wdata & VALID_MASK;
                default: ;
            endcase
        end
        // A fresh event overrides a clear of the same bit.
        st_d.status = ((st_q.status & ~clr_mask) | evt) & VALID_MASK;
        st_d.irq    = |st_q.status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_kind)
            K_STAT:  rdata = st_q.status;
            K_RISE:  rdata = st_q.rise_en;
            K_FALL:  rdata = st_q.fall_en;
            K_HIGH:  rdata = st_q.high_en;
            K_LOW:   rdata = st_q.low_en;
            K_ARISE: rdata = st_q.arise_st;
            K_AFALL: rdata = st_q.afall_st;
            default: rdata = '0;
        endcase
    end

    assign status = st_q.status;
    assign irq    = st_q.irq;

endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int ADDR_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic [NUM_PINS-1:0]           pin_level,
    output logic [(NUM_PINS+31)/32-1:0]   bank_irq
);

    localparam int NUM_BANKS = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int PAD_W     = NUM_BANKS * WORD_W;

    evt_kind_e           dec_kind;
    logic [BIDX_W-1:0]   dec_bank;
    logic                dec_hit;
    logic [PAD_W-1:0]    level_pad;
    logic [PAD_W-1:0]    status_flat;
    word_t               rd_words [NUM_BANKS];

    gpio_evt_regdec #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .BIDX_W    (BIDX_W)
    ) u_regdec (
        .addr (reg_addr),
        .kind (dec_kind),
        .bank (dec_bank),
        .hit  (dec_hit)
    );

    always_comb begin
        level_pad                 = '0;
        level_pad[NUM_PINS-1:0]   = pin_level;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int    PINS_HERE = ((NUM_PINS - WORD_W * b) > WORD_W) ? WORD_W
                                                                       : (NUM_PINS - WORD_W * b);
        localparam word_t MASK      = (PINS_HERE == WORD_W) ? '1
                                                            : word_t'((64'd1 << PINS_HERE) - 64'd1);
        logic bank_wr;

        assign bank_wr = reg_wr & dec_hit & (dec_bank == BIDX_W'(b));

        gpio_evt_bank #(
            .VALID_MASK (MASK)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr),
            .wr_kind (dec_kind),
            .wdata   (reg_wdata),
            .level   (level_pad[b*WORD_W +: WORD_W]),
            .rd_kind (dec_kind),
            .rdata   (rd_words[b]),
            .status  (status_flat[b*WORD_W +: WORD_W]),
            .irq     (bank_irq[b])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (dec_hit) begin
            reg_rdata = rd_words[dec_bank];
        end
    end

endmodule

// File: rtl/gpio_event_unit_chk.sv
module gpio_event_unit_chk #(
    parameter int NUM_PINS = 54,
    parameter int ADDR_W   = 8
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                reg_wr,
    input logic [ADDR_W-1:0]                   reg_addr,
    input logic [31:0]                         reg_wdata,
    input logic [(NUM_PINS+31)/32-1:0]         bank_irq,
    input logic [((NUM_PINS+31)/32)*32-1:0]    status_flat
);

    localparam int NB       = (NUM_PINS + 31) / 32;
    localparam int STAT_ADR = 'h40;

    // R1: reset empties all status and interrupt state
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (status_flat == '0 && bank_irq == '0));

    for (genvar b = 0; b < NB; b++) begin : g_irq
        // R10: interrupt is the OR of the bank's status one clock earlier
        p_irq_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (bank_irq[b] == $past(|status_flat[b*32 +: 32])));
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_sticky
        // R8: a set bit survives unless its own bit is written as one
        p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (status_flat[i] &&
             !(reg_wr && reg_addr == ADDR_W'(STAT_ADR + 4 * (i / 32)) && reg_wdata[i % 32]))
            |=> status_flat[i]);
    end

    for (genvar j = NUM_PINS; j < NB * 32; j++) begin : g_pad
        // R2: bits beyond the pin count never hold status
        p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            status_flat[j] == 1'b0);
    end

endmodule

bind gpio_event_unit gpio_event_unit_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .bank_irq    (bank_irq),
    .status_flat (status_flat)
);

// File: tb/gpio_event_unit_tb_top.sv
`timescale 1ns/1ps
module gpio_event_unit_tb_top;

    localparam int NPINS = 54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NPINS-1:0] pins = '0;
    logic [1:0]  bank_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference state: index 0 = status, 1..6 = enable/storage families
    bit [63:0] m_reg [7];
    bit [63:0] m_prev;
    bit [1:0]  m_irq;

    always #5 clk = ~clk;

    gpio_event_unit #(.NUM_PINS(NPINS), .ADDR_W(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_level (pins),
        .bank_irq  (bank_irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void decode(input logic [7:0] a, output int k, output int b);
        k = -1;
        b = 0;
        for (int kk = 0; kk < 7; kk++)
            for (int bb = 0; bb < 2; bb++)
                if (a == 8'(64 + 12 * kk + 4 * bb)) begin
                    k = kk;
                    b = bb;
                end
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int k, b;
        logic [31:0] w;
        decode(a, k, b);
        w = '0;
        if (k >= 0) w = m_reg[k][b*32 +: 32];
        return w;
    endfunction

    task automatic model_step();
        bit [63:0] n_st;
        bit [1:0]  n_irq;
        int wk, wb;
        for (int b = 0; b < 2; b++) n_irq[b] = |m_reg[0][b*32 +: 32];
        wk = -1;
        wb = 0;
        if (reg_wr) decode(reg_addr, wk, wb);
        for (int p = 0; p < 64; p++) begin
            bit lv, ev, clr;
            lv  = (p < NPINS) ? pins[p] : 1'b0;
            ev  = (m_reg[1][p] && !m_prev[p] && lv) ||
                  (m_reg[2][p] && m_prev[p] && !lv) ||
                  (m_reg[3][p] && lv) ||
                  (m_reg[4][p] && !lv);
            clr = (wk == 0) && (wb == p / 32) && reg_wdata[p % 32];
            n_st[p] = (m_reg[0][p] && !clr) || ev;
            if (wk >= 1 && wb == p / 32 && p < NPINS) m_reg[wk][p] = reg_wdata[p % 32];
            m_prev[p] = lv;
        end
        m_reg[0] = n_st;
        m_irq    = n_irq;
    endtask

    task automatic compare();
        for (int b = 0; b < 2; b++)
            check(bank_irq[b] === m_irq[b], cur_req, 32'(bank_irq[b]), 32'(m_irq[b]));
        check(reg_rdata === model_read(reg_addr), cur_req, reg_rdata, model_read(reg_addr));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        cyc();
        reg_wr    = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        check(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    task automatic chk_irq(input logic [1:0] exp, input string req);
        check(bank_irq === exp, req, 32'(bank_irq), 32'(exp));
    endtask

    initial begin
        for (int k = 0; k < 7; k++) m_reg[k] = '0;
        m_prev = '0;
        m_irq  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: everything zero after reset
        for (int a = 'h40; a < 'h90; a += 4) chk_rd(8'(a), 32'h0, "R1");
        chk_irq(2'b00, "R1");
        rst_n = 1'b1;
        cyc();

        // R2: map, partial bank, unmapped address
        cur_req = "R2";
        wr(8'h50, 32'hFFFF_FFFF);
        chk_rd(8'h50, 32'h003F_FFFF, "R2");
        chk_rd(8'h4C, 32'h0, "R2");
        wr(8'h48, 32'hFFFF_FFFF);
        chk_rd(8'h48, 32'h0, "R2");
        chk_rd(8'h40, 32'h0, "R2");
        wr(8'h50, 32'h0);
        chk_rd(8'h50, 32'h0, "R2");

        // R3, R8, R10, R12 on pin 5
        cur_req = "R3";
        wr(8'h4C, 32'h20);
        pins[5] = 1'b1;
        cyc();
        chk_rd(8'h40, 32'h20, "R3");
        chk_irq(2'b00, "R10");
        cyc();
        chk_irq(2'b01, "R10");
        cur_req = "R8";
        wr(8'h40, 32'h0);
        chk_rd(8'h40, 32'h20, "R8");
        wr(8'h40, 32'h20);
        chk_rd(8'h40, 32'h0, "R8");
        cur_req = "R12";
        pins[5] = 1'b0;
        cyc();
        chk_rd(8'h40, 32'h0, "R12");
        wr(8'h4C, 32'h0);

        // R4 on pin 40 (bank 1 bit 8)
        cur_req = "R4";
        wr(8'h5C, 32'h100);
        pins[40] = 1'b1;
        cyc();
        chk_rd(8'h44, 32'h0, "R12");
        pins[40] = 1'b0;
        cyc();
        chk_rd(8'h44, 32'h100, "R4");
        wr(8'h44, 32'h100);
        wr(8'h5C, 32'h0);

        // R5 on pin 3
        cur_req = "R5";
        wr(8'h4C, 32'h8);
        wr(8'h58, 32'h8);
        pins[3] = 1'b1;
        cyc();
        chk_rd(8'h40, 32'h8, "R5");
        wr(8'h40, 32'h8);
        chk_rd(8'h40, 32'h0, "R5");
        pins[3] = 1'b0;
        cyc();
        chk_rd(8'h40, 32'h8, "R5");
        wr(8'h40, 32'h8);
        wr(8'h4C, 32'h0);
        wr(8'h58, 32'h0);

        // R6 on pin 33 (bank 1 bit 1)
        cur_req = "R6";
        pins[33] = 1'b1;
        wr(8'h68, 32'h2);
        chk_rd(8'h44, 32'h0, "R6");
        cyc();
        chk_rd(8'h44, 32'h2, "R6");
        wr(8'h44, 32'h2);
        chk_rd(8'h44, 32'h2, "R6");
        pins[33] = 1'b0;
        cyc();
        wr(8'h44, 32'h2);
        chk_rd(8'h44, 32'h0, "R6");
        wr(8'h68, 32'h0);

        // R7 on pin 10
        cur_req = "R7";
        wr(8'h70, 32'h400);
        cyc();
        chk_rd(8'h40, 32'h400, "R7");
        pins[10] = 1'b1;
        wr(8'h70, 32'h0);
        wr(8'h40, 32'h400);
        chk_rd(8'h40, 32'h0, "R7");

        // R9: clear and new edge in the same cycle
        cur_req = "R9";
        pins[5] = 1'b0;
        wr(8'h4C, 32'h20);
        pins[5] = 1'b1;
        cyc();
        pins[5] = 1'b0;
        cyc();
        pins[5] = 1'b1;
        wr(8'h40, 32'h20);
        chk_rd(8'h40, 32'h20, "R9");
        wr(8'h40, 32'h20);
        chk_rd(8'h40, 32'h0, "R9");
        wr(8'h4C, 32'h0);

        // R11: asynchronous families are storage only
        cur_req = "R11";
        wr(8'h7C, 32'hFFFF_FFFF);
        wr(8'h88, 32'hFFFF_FFFF);
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'h8C, 32'hFFFF_FFFF);
        for (int i = 0; i < 4; i++) begin
            pins = ~pins;
            cyc();
        end
        chk_rd(8'h40, 32'h0, "R11");
        chk_rd(8'h44, 32'h0, "R11");
        chk_irq(2'b00, "R11");
        chk_rd(8'h7C, 32'hFFFF_FFFF, "R2");
        chk_rd(8'h80, 32'h003F_FFFF, "R2");
        wr(8'h7C, 32'h0);
        wr(8'h88, 32'h0);
        wr(8'h80, 32'h0);
        wr(8'h8C, 32'h0);
        chk_rd(8'h8C, 32'h0, "R11");

        // R10: pin 53 reaches only bank 1
        cur_req = "R10";
        pins = '0;
        cyc();
        wr(8'h50, 32'h0020_0000);
        pins[53] = 1'b1;
        cyc();
        cyc();
        chk_irq(2'b10, "R10");
        wr(8'h44, 32'h0020_0000);
        wr(8'h50, 32'h0);
        cyc();
        chk_irq(2'b00, "R10");

        // mixed random traffic against the model (R3..R9, R12)
        cur_req = "R3-mixed";
        for (int i = 0; i < 3000; i++) begin
            pins = {$urandom, $urandom} & {NPINS{1'b1}};
            if (($urandom % 4) == 0) begin
                int k, b;
                k = $urandom % 5;
                b = $urandom % 2;
                reg_wr    = 1'b1;
                reg_addr  = 8'(64 + 12 * k + 4 * b);
                reg_wdata = $urandom & $urandom;
            end else begin
                reg_wr   = 1'b0;
                reg_addr = 8'(64 + 4 * ($urandom % 2));
            end
            cyc();
        end
        reg_wr = 1'b0;

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule